// File: doc/BRIEF.md
# Signed-Count Logical Shift Unit

This block is a logical shifter for a DSP datapath. It takes one 16-bit signed count and uses it to set both the direction and the distance of a shift. A positive count shifts left. A negative count shifts right by its magnitude. Vacated bit positions are always filled with zeros, whatever the sign of the operand.

A two-bit mode input selects the width the shift acts on:

- one 16-bit half of a 32-bit operand;
- two independent 16-bit lanes of that operand;
- the whole 32-bit word;
- a separate 40-bit accumulator input.

In half mode, `src_hi` picks which half of the operand is shifted, and `dst_hi` picks which half of the result receives it. The two write-select outputs tell the register file which half or halves to update.

The shift logic is combinational. A single output register follows it and captures a new result whenever `in_valid` is high. The latency is therefore one clock cycle.

Top module: `lshift_unit`

## Requirements
- R1: The count is read as a 16-bit two's-complement value. Values 0 to 32767 shift left by that amount. Values -1 to -32768 shift right by the magnitude. For example, count 0x0003 and count 0xFFFD applied to the same word shift it three places in opposite directions.
- R2: Right shifts fill with zeros in every mode, even when the top bit of the lane is set. For example, 0x80F0 shifted right by one gives 0x4078.
- R3: Half mode is `mode` = 2'b00.
  - The source half is operand[31:16] when `src_hi`=1, and operand[15:0] otherwise.
  - It is shifted within 16 bits, and bits moved past bit 15 are lost. For example, 0xC00F shifted left by one gives 0x801E.
  - The result goes to result[31:16] if `dst_hi`=1, or to result[15:0] if `dst_hi`=0.
  - Every other result bit is zero.
- R4: The write selects follow the mode. In half mode, exactly one of `out_wr_hi`/`out_wr_lo` is 1, and it is `out_wr_hi` exactly when `dst_hi`=1. In every other mode, both are 1.
- R5: Vector mode is `mode` = 2'b01. The halves operand[31:16] and operand[15:0] are each shifted by the count as separate 16-bit lanes, and no bit crosses between them. For example, 0x10001000 shifted right by two gives 0x04000400.
- R6: Word mode is `mode` = 2'b10. All 32 bits of the operand shift as one value, and result[39:32] is zero. For example, 0xC80FE00F shifted left by four gives 0x80FE00F0.
- R7: Accumulator mode is `mode` = 2'b11. All 40 bits of `acc_in` shift as one value, and the result uses all 40 bits.
- R8: When the count magnitude is equal to or larger than the lane width (16, 32 or 40 bits), that lane's result is all zeros.
- R9: `out_valid` is high in the cycle after `in_valid` was high, and the result and write selects it qualifies belong to that input. While `in_valid` is low, the result and the write selects keep their values.
- R10: After a synchronous active-low reset, `out_valid`, `result`, `out_wr_hi` and `out_wr_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture a new result at the next edge |
| mode | input | 2 | 00 half, 01 vector, 10 word, 11 accumulator |
| src_hi | input | 1 | Half mode: shift the upper operand half |
| dst_hi | input | 1 | Half mode: place the result in the upper half |
| operand | input | 32 | Data for the half, vector and word modes |
| acc_in | input | 40 | Data for accumulator mode |
| count | input | 16 | Signed shift count |
| out_valid | output | 1 | The registered result is new this cycle |
| result | output | 40 | Shifted value |
| out_wr_hi | output | 1 | Write select for the upper half |
| out_wr_lo | output | 1 | Write select for the lower half |

## Verification
The assertions check the following on every cycle:
- `out_valid` tracks `in_valid` with one cycle of delay, and the output holds while `in_valid` is low.
- At least one write select is active whenever `out_valid` is high.
- In half mode, the half that was not written is zero.
- The eight upper bits are zero outside accumulator mode.
- Each lane leaves a zero at the end it vacates.

Only the bench's sweeps can show that the shifted values themselves are correct. The sweeps cover every mode, every count from -40 to +40, and both half selections. They also show where the 16-, 32- and 40-bit zeroing thresholds fall and how the extreme count values are handled.

// File: rtl/lshift_pkg.sv
// Package for the signed-count logical shifter.
// It holds the mode encoding and the default widths.
// It assumes the mode field is two bits wide.
package lshift_pkg;
    localparam int LANE_W_DEF = 16;
    localparam int WORD_W_DEF = 32;
    localparam int ACC_W_DEF  = 40;
    localparam int CNT_W_DEF  = 16;

    typedef enum logic [1:0] {
        SH_HALF = 2'b00,
        SH_VEC  = 2'b01,
        SH_WORD = 2'b10,
        SH_ACC  = 2'b11
    } shift_mode_e;
endpackage

// File: rtl/lshift_count_dec.sv
// Count decoder.
// It splits a two's-complement count into a direction and an unsigned magnitude.
// It assumes CNT_W >= 2. The most negative count gives a magnitude of 2**(CNT_W-1),
// and that still fits in CNT_W bits.
module lshift_count_dec #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    output logic             shl,
    output logic [CNT_W-1:0] mag
);
    // Decode direction and magnitude from the sign bit.
    always_comb begin
        shl = ~count[CNT_W-1];
        mag = count[CNT_W-1] ? (~count + 1'b1) : count;
    end

    // R1: a left decode always has a positive magnitude below half range
    always_comb begin
        if (shl) begin
            dir_mag_chk: assert (mag[CNT_W-1] == 1'b0);
        end
    end
endmodule

// File: rtl/lshift_lane.sv
// One logical-shift lane of width W.
// It shifts left or right by an unsigned magnitude and fills with zeros.
// A magnitude of W or more clears the lane.
// It assumes W < 2**CNT_W.
module lshift_lane #(
    parameter int W     = 16,
    parameter int CNT_W = 16
) (
    input  logic [W-1:0]     din,
    input  logic             shl,
    input  logic [CNT_W-1:0] mag,
    output logic [W-1:0]     dout
);
    localparam logic [CNT_W-1:0] W_CNT = CNT_W'(W);

    logic too_far;

    // Detect a distance that clears the whole lane.
    always_comb too_far = (mag >= W_CNT);

    // Shift in the decoded direction, or clear the lane.
    always_comb begin
        if (too_far)  dout = '0;
        else if (shl) dout = din << mag;
        else          dout = din >> mag;
    end

    // R2 / R8: the vacated end of the lane is zero after any non-zero shift
    always_comb begin
        if (mag != '0) begin
            if (shl) begin
                // R8
                zero_lsb_chk: assert (dout[0] == 1'b0);
            end else begin
                // R2
                zero_fill_chk: assert (dout[W-1] == 1'b0);
            end
        end
    end
endmodule

// File: rtl/lshift_unit.sv
// Signed-count logical shift unit with a registered output.
// One count drives four lane shifters: two 16-bit lanes, one 32-bit word and one
// accumulator-width lane. The mode picks which of these results is used, and the
// output register captures it when in_valid is high.
// It assumes ACC_W > WORD_W = 2*LANE_W.
module lshift_unit
    import lshift_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int WORD_W = WORD_W_DEF,
    parameter int ACC_W  = ACC_W_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic              src_hi,
    input  logic              dst_hi,
    input  logic [WORD_W-1:0] operand,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [CNT_W-1:0]  count,
    output logic              out_valid,
    output logic [ACC_W-1:0]  result,
    output logic              out_wr_hi,
    output logic              out_wr_lo
);
    localparam int NLANE = WORD_W / LANE_W;
    localparam int PAD_W = ACC_W - WORD_W;

    shift_mode_e       mode_e;
    logic              shl;
    logic [CNT_W-1:0]  mag;
    logic [LANE_W-1:0] lane_out [NLANE];
    logic [WORD_W-1:0] word_out;
    logic [ACC_W-1:0]  acc_out;
    logic [LANE_W-1:0] half_val;
    logic [ACC_W-1:0]  nxt_result;
    logic              nxt_wr_hi;
    logic              nxt_wr_lo;

    // Interpret the raw mode bits as the package enumeration.
    always_comb mode_e = shift_mode_e'(mode);

    lshift_count_dec #(.CNT_W(CNT_W)) u_dec (
        .count (count),
        .shl   (shl),
        .mag   (mag)
    );

    // Independent 16-bit lanes, used by the vector and half modes.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        lshift_lane #(.W(LANE_W), .CNT_W(CNT_W)) u_lane (
            .din  (operand[g*LANE_W +: LANE_W]),
            .shl  (shl),
            .mag  (mag),
            .dout (lane_out[g])
        );
    end

    lshift_lane #(.W(WORD_W), .CNT_W(CNT_W)) u_word (
        .din  (operand),
        .shl  (shl),
        .mag  (mag),
        .dout (word_out)
    );

    lshift_lane #(.W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .din  (acc_in),
        .shl  (shl),
        .mag  (mag),
        .dout (acc_out)
    );

    // Pick the shifted half selected by src_hi.
    always_comb half_val = src_hi ? lane_out[NLANE-1] : lane_out[0];

    // Assemble the next result and write selects for the current mode.
    always_comb begin
        nxt_result = '0;
        nxt_wr_hi  = 1'b1;
        nxt_wr_lo  = 1'b1;
        unique case (mode_e)
            SH_HALF: begin
                if (dst_hi) nxt_result[WORD_W-1:LANE_W] = half_val;
                else        nxt_result[LANE_W-1:0]      = half_val;
                nxt_wr_hi = dst_hi;
                nxt_wr_lo = ~dst_hi;
            end
            SH_VEC: begin
                for (int i = 0; i < NLANE; i++) begin
                    nxt_result[i*LANE_W +: LANE_W] = lane_out[i];
                end
            end
            SH_WORD: nxt_result = {{PAD_W{1'b0}}, word_out};
            SH_ACC:  nxt_result = acc_out;
            default: nxt_result = '0;
        endcase
    end

    // Output register: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            out_wr_hi <= 1'b0;
            out_wr_lo <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= nxt_result;
                out_wr_hi <= nxt_wr_hi;
                out_wr_lo <= nxt_wr_lo;
            end
        end
    end

    // R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(result) && $stable(out_wr_hi) && $stable(out_wr_lo)));

    // R4
    write_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wr_hi || out_wr_lo));

    // R3
    half_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_wr_hi != out_wr_lo)) |->
            ((out_wr_hi ? (result[LANE_W-1:0] == '0) : (result[WORD_W-1:LANE_W] == '0))
             && (result[ACC_W-1:WORD_W] == '0)));

    // R6
    upper_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) != SH_ACC) |-> (result[ACC_W-1:WORD_W] == '0));
endmodule

// File: tb/tb_lshift_unit.sv
module tb_lshift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        src_hi = 1'b0;
    logic        dst_hi = 1'b0;
    logic [31:0] operand = '0;
    logic [39:0] acc_in = '0;
    logic [15:0] count = '0;
    logic        out_valid;
    logic [39:0] result;
    logic        out_wr_hi;
    logic        out_wr_lo;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lshift_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .src_hi(src_hi), .dst_hi(dst_hi), .operand(operand), .acc_in(acc_in),
        .count(count), .out_valid(out_valid), .result(result),
        .out_wr_hi(out_wr_hi), .out_wr_lo(out_wr_lo)
    );

    // Reference model: a logical shift of a w-bit value done with multiply and divide.
    function automatic logic [63:0] ref_shift(logic [63:0] x, int w, int c);
        int m;
        logic [63:0] modulus;
        m = (c < 0) ? -c : c;
        if (m >= w) return 64'd0;
        modulus = 64'd1 << w;
        if (c >= 0) return (x * (64'd1 << m)) % modulus;
        return x / (64'd1 << m);
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one operation, then compare the registered output one edge later.
    task automatic apply(logic [1:0] md, logic [31:0] op, logic [39:0] acc,
                         int c, logic sh, logic dh, string tag);
        logic [39:0] exp;
        logic [15:0] h;
        int width;
        logic [15:0] src;
        width = (md == 2'b00 || md == 2'b01) ? 16 : (md == 2'b10) ? 32 : 40;
        src = sh ? op[31:16] : op[15:0];
        h = ref_shift({48'd0, src}, 16, c);
        case (md)
            2'b00:   exp = dh ? {8'd0, h, 16'd0} : {24'd0, h};
            2'b01:   exp = {8'd0, 16'(ref_shift({48'd0, op[31:16]}, 16, c)),
                                 16'(ref_shift({48'd0, op[15:0]}, 16, c))};
            2'b10:   exp = {8'd0, 32'(ref_shift({32'd0, op}, 32, c))};
            default: exp = 40'(ref_shift({24'd0, acc}, 40, c));
        endcase
        @(negedge clk);
        mode = md;
        operand = op;
        acc_in = acc;
        count = 16'(c);
        src_hi = sh;
        dst_hi = dh;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(((c >= width) || (-c >= width)) ? "R8" : tag, {24'd0, result}, {24'd0, exp});
        check("R9", {63'd0, out_valid}, 64'd1);
        if (md == 2'b00) begin
            check("R4", {62'd0, out_wr_hi, out_wr_lo}, {62'd0, dh, ~dh});
        end else begin
            check("R4", {62'd0, out_wr_hi, out_wr_lo}, 64'd3);
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ops [8];
        logic [31:0] lfsr;
        logic [39:0] hold;

        ops[0] = 32'h80F080F0;
        ops[1] = 32'hC80FE00F;
        ops[2] = 32'h30000003;
        ops[3] = 32'h00010001;
        ops[4] = 32'h10001000;
        ops[5] = 32'hFFFFFFFF;
        lfsr = 32'h1D2C3B4A;
        for (int i = 6; i < 8; i++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            ops[i] = lfsr;
        end

        // R10: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", {22'd0, out_valid, result, out_wr_hi, out_wr_lo}, 64'd0);
        rst_n = 1'b1;

        // Directed cases from the requirement text
        apply(2'b00, 32'h000080F0, 40'd0, -1, 1'b0, 1'b0, "R2");
        apply(2'b00, 32'hC00F0000, 40'd0, 1, 1'b1, 1'b1, "R3");
        apply(2'b01, 32'h10001000, 40'd0, -2, 1'b0, 1'b0, "R5");
        apply(2'b10, 32'hC80FE00F, 40'd0, 4, 1'b0, 1'b0, "R6");
        apply(2'b11, 40'd0, 40'h0000010001, 3, 1'b0, 1'b0, "R7");
        apply(2'b10, 32'h30000003, 40'd0, 3, 1'b0, 1'b0, "R1");
        apply(2'b10, 32'h30000003, 40'd0, -3, 1'b0, 1'b0, "R1");
        apply(2'b11, 40'd0, 40'hFF80000001, 32767, 1'b0, 1'b0, "R8");
        apply(2'b11, 40'd0, 40'hFF80000001, -32768, 1'b0, 1'b0, "R8");
        apply(2'b10, 32'hFFFFFFFF, 40'd0, 31, 1'b0, 1'b0, "R6");
        apply(2'b00, 32'hFFFFFFFF, 40'd0, -15, 1'b1, 1'b0, "R3");

        // Sweep every mode over counts -40..40 for each operand
        for (int k = 0; k < 8; k++) begin
            for (int c = -40; c <= 40; c++) begin
                for (int s = 0; s < 4; s++) begin
                    apply(2'b00, ops[k], 40'd0, c, s[1], s[0], "R3");
                end
                apply(2'b01, ops[k], 40'd0, c, 1'b0, 1'b0, "R5");
                apply(2'b10, ops[k], 40'd0, c, 1'b0, 1'b0, "R6");
                apply(2'b11, ops[k], {ops[k][7:0] ^ 8'hA5, ops[k]}, c, 1'b0, 1'b0, "R7");
            end
        end

        // R9: the output holds while in_valid is low
        apply(2'b11, 32'd0, 40'hC3_1234_5678, 1, 1'b0, 1'b0, "R7");
        hold = result;
        @(negedge clk);
        mode = 2'b00;
        operand = 32'hFFFFFFFF;
        count = 16'd0;
        dst_hi = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", {24'd0, result}, {24'd0, hold});
        check("R9", {61'd0, out_valid, out_wr_hi, out_wr_lo}, 64'd3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule